// File: doc/BRIEF.md
# Modem Status and Control Register

This block holds the modem handshake state of one serial channel. A five-bit control register drives four active-low handshake outputs (terminal ready, request to send, and two general-purpose outputs) and a loopback switch. Four active-low handshake inputs (clear to send, set ready, ring, carrier) are synchronised and presented, inverted, in the upper half of an eight-bit status byte. The lower half holds sticky change flags that clear when the byte is read. Any set flag raises an interrupt request.

In loopback the outputs go to their inactive high level. The four status levels are then taken from the control bits rather than the pins, so software can test its handshake and interrupt handling without a cable. The neighbouring register file performs the write decode and the read strobe. This block only needs a write enable, a read-strobe pulse and the data.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control register is 0, all four outputs are 1, the status byte is 0 when all input pins are high, and `irq` is 0.
- R2: Control bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is loopback. Outside loopback, a set bit drives its output pin to 0 and a clear bit drives it to 1. This takes effect in the cycle after the write edge.
- R3: Status bits 7..4 are the complements of `dcd_n`, `ri_n`, `dsr_n` and `cts_n`. A pin change appears there after two clock edges.
- R4: Status bits 3, 1 and 0 (carrier, set-ready and clear-to-send change flags) set on any change of the matching level. This happens one edge after the level changes, and the flag stays set until it is read.
- R5: Status bit 2 sets only when `ri_n` goes from low to high, that is when status bit 6 falls. A rise of bit 6 leaves bit 2 clear.
- R6: A `rd_stat` pulse clears all four change flags at its edge. A change detected at the same edge is kept for the next read.
- R7: `irq` is 1 exactly when at least one of status bits 3..0 is 1.
- R8: In loopback all four output pins are 1. The status levels come from RTS→CTS, DTR→DSR, OUT1→RI and OUT2→DCD, and change flags follow these internal levels.
- R9: `ctrl_q` returns the written control register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wdata | input | 5 | Control value to write |
| rd_stat | input | 1 | Status read strobe, clears change flags |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| ctrl_q | output | 5 | Control register readback |
| status | output | 8 | Status byte: levels 7..4, change flags 3..0 |
| irq | output | 1 | Modem status interrupt request |

## Verification
A status read and a newly detected input change can land on the same clock edge. If that happens, the clear must not swallow the new flag. The bench provokes this case by dropping `cts_n`, waiting until the synchronised level has moved, and then raising `rd_stat` in the very cycle in which the change is detected. It then judges the byte that follows: the clear-to-send change flag and `irq` must still be set. It also checks that a read with no change pending leaves all flags clear.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [4:0] wdata,
  input  logic       rd_stat,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out1_n,
  output logic       out2_n,
  output logic [4:0] ctrl_q,
  output logic [7:0] status,
  output logic       irq
);

  localparam int LVL = 4;

  logic [4:0]     ctrl;
  logic [LVL-1:0] sync [SYNC_STAGES];
  logic [LVL-1:0] lvl, lvl_prev, chg, flags;
  logic           loop;

  assign loop = ctrl[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= wdata;

  // pin order {dcd, ri, dsr, cts}
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync[i] <= '1;
      else if (i == 0) sync[i] <= {dcd_n, ri_n, dsr_n, cts_n};
      else sync[i] <= sync[i-1];
  end

  assign lvl = loop ? {ctrl[3], ctrl[2], ctrl[0], ctrl[1]}
                    : ~sync[SYNC_STAGES-1];

  assign chg = {lvl[3] ^ lvl_prev[3],
                lvl_prev[2] & ~lvl[2],
                lvl[1] ^ lvl_prev[1],
                lvl[0] ^ lvl_prev[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_prev <= '0;
      flags    <= '0;
    end else begin
      lvl_prev <= lvl;
      flags    <= rd_stat ? chg : (flags | chg);
    end

  assign dtr_n  = loop | ~ctrl[0];
  assign rts_n  = loop | ~ctrl[1];
  assign out1_n = loop | ~ctrl[2];
  assign out2_n = loop | ~ctrl[3];
  assign ctrl_q = ctrl;
  assign status = {lvl, flags};
  assign irq    = |flags;

  assert_cts_delta_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] != lvl_prev[0]) |=> status[0]);
  assert_teri_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(lvl_prev[2] && !lvl[2]));
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && chg == '0) |=> status[3:0] == '0);
  assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> (dtr_n && rts_n && out1_n && out2_n));
  assert_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> (dtr_n == !ctrl_q[0] && out2_n == !ctrl_q[3]));
  assert_irq_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(chg != '0));

endmodule

// File: tb/tb_modem_ctl_stat.sv
module tb_modem_ctl_stat;
  logic clk = 0, rst_n = 0, wr_ctrl = 0, rd_stat = 0;
  logic [4:0] wdata = '0;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic dtr_n, rts_n, out1_n, out2_n, irq;
  logic [4:0] ctrl_q;
  logic [7:0] status;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  modem_ctl_stat dut (.*);

  // entry: {pins dcd,ri,dsr,cts (active low), expected status}
  localparam logic [11:0] VEC [9] = '{
    {4'b1110, 8'h11}, {4'b1100, 8'h32}, {4'b1000, 8'h70},
    {4'b1100, 8'h34}, {4'b0100, 8'hB8}, {4'b1111, 8'h0B},
    {4'b1111, 8'h00}, {4'b0000, 8'hFB}, {4'b1111, 8'h0F}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd();
    rd_stat = 1; step(1); rd_stat = 0;
  endtask

  task automatic wr(logic [4:0] v);
    wdata = v; wr_ctrl = 1; step(1); wr_ctrl = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); rst_n = 1; step(1);
    chk("R1 status", status, 8'h00);
    chk("R1 pins", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    chk("R1 irq", {7'b0, irq}, 8'h0);
    chk("R1 ctrl", {3'b0, ctrl_q}, 8'h00);

    for (int i = 0; i < 9; i++) begin
      {dcd_n, ri_n, dsr_n, cts_n} = VEC[i][11:8];
      step(3);
      chk($sformatf("R3/R4/R5 vec%0d", i), status, VEC[i][7:0]);
      chk($sformatf("R7 vec%0d", i), {7'b0, irq}, {7'b0, |VEC[i][3:0]});
      rd();
      chk($sformatf("R6 clear vec%0d", i), status, {VEC[i][7:4], 4'h0});
    end

    wr(5'b01111);
    chk("R2 all set", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h00);
    chk("R9 readback", {3'b0, ctrl_q}, 8'h0F);
    wr(5'b00101);
    chk("R2 mixed", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'b0000_0101);
    wr(5'b00000);

    cts_n = 0; step(2);
    chk("R3 level before read", status, 8'h10);
    rd();
    chk("R6 coincident change kept", status, 8'h11);
    chk("R7 irq kept", {7'b0, irq}, 8'h1);
    rd();
    chk("R6 later read clears", status, 8'h10);
    cts_n = 1; step(3); rd();

    wr(5'b10000);
    chk("R8 loop no change", status, 8'h00);
    wr(5'b10011);
    chk("R8 outputs inactive", {4'b0, dtr_n, rts_n, out1_n, out2_n}, 8'h0F);
    chk("R8 levels", status, 8'h30);
    step(1);
    chk("R8 deltas", status, 8'h33);
    rd();
    wr(5'b11100); step(1);
    chk("R8 out2/out1 map", status, 8'hCB);
    rd();
    wr(5'b10000); step(1);
    chk("R5 loop trailing ring", status, 8'h0C);
    rd();
    cts_n = 0; step(3);
    chk("R8 pins ignored", status, 8'h00);
    wr(5'b00000); step(1);
    chk("R8 leave loop", status, 8'h11);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule